// File: doc/BRIEF.md
# Mode-Dependent Sample Interrupt Generator

This block produces a free-running, active-low sample interrupt from the master clock. The receiving processor uses it as a cue that a data sample can be exchanged, and as a steady timing mark for its own scheduling. The pulse needs no acknowledge. Each period is followed directly by the next one until the interrupt is turned off.

A mode input selects one of two operating modes. In digital mode the interrupt repeats every 800 master clock cycles (48.6 kHz at 38.88 MHz) and stays low for 6.5 cycles. In analog mode it repeats every 972 cycles (40 kHz) and stays low for 5.5 cycles. The extra half cycle comes from a copy of the rising-edge pulse that is registered on the falling clock edge. A new mode is adopted only at a period boundary. A disable input holds the output high. When the interrupt is enabled again, the next period starts from zero.

Top module: `sample_irq_gen`

## Requirements
- R1: With mode_sel=1 (digital), consecutive falling edges of irq_n are 800 clock cycles apart while the block stays enabled.
- R2: With mode_sel=0 (analog), consecutive falling edges of irq_n are 972 clock cycles apart while the block stays enabled.
- R3: In digital mode each low phase of irq_n lasts exactly 6.5 clock cycles.
- R4: In analog mode each low phase of irq_n lasts exactly 5.5 clock cycles.
- R5: A low phase of irq_n begins at a rising clock edge and ends at a falling clock edge.
- R6: While irq_disable=1, irq_n stays high and produces no pulse.
- R7: When irq_disable returns to 0, the next low phase begins at the first rising edge that samples irq_disable=0, and the following period has the full length of the selected mode.
- R8: A change of mode_sel is adopted only at the next period boundary. The pulse in progress keeps its width and the period in progress keeps its length. While the block is disabled, the mode is adopted at once.
- R9: Synchronous reset (rst=1) holds irq_n high. The first low phase begins at the first rising edge that samples rst=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 1 = digital mode, 0 = analog mode |
| irq_disable | input | 1 | 1 suppresses the interrupt |
| irq_n | output | 1 | Active-low sample interrupt |

## Verification
A wrong count or a wrongly latched mode shows up as a shifted falling edge of irq_n. This is visible one period after the fault at the latest, because the bench times every edge against the expected period of the mode that is in force. A fault in the half-cycle stage shows up within the same pulse as a low phase that is an integer number of cycles long. A counter that does not restart after a disable is exposed by the time of the first pulse after re-enable, which the bench measures in absolute time.

// File: rtl/sample_irq_pkg.sv
package sample_irq_pkg;
    typedef enum logic {
        MODE_ANALOG  = 1'b0,
        MODE_DIGITAL = 1'b1
    } irq_mode_e;
endpackage

// File: rtl/sample_irq_counter.sv
module sample_irq_counter
    import sample_irq_pkg::*;
#(
    parameter int DIG_PERIOD = 800,
    parameter int ANA_PERIOD = 972,
    parameter int DIG_LOW    = 6,
    parameter int ANA_LOW    = 5,
    parameter int CNT_W      = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic mode_i,
    output logic low_req_o
);
    localparam logic [CNT_W-1:0] DIG_LAST = CNT_W'(DIG_PERIOD - 1);
    localparam logic [CNT_W-1:0] ANA_LAST = CNT_W'(ANA_PERIOD - 1);
    localparam logic [CNT_W-1:0] DIG_W    = CNT_W'(DIG_LOW);
    localparam logic [CNT_W-1:0] ANA_W    = CNT_W'(ANA_LOW);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        irq_mode_e        mode;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] low_len;

    always_comb begin
        last_cnt = (st_q.mode == MODE_DIGITAL) ? DIG_LAST : ANA_LAST;
        low_len  = (st_q.mode == MODE_DIGITAL) ? DIG_W : ANA_W;
        st_d     = st_q;
        if (rst || !en_i) begin
            st_d.cnt  = '0;
            st_d.mode = irq_mode_e'(mode_i);
        end else if (st_q.cnt == last_cnt) begin
            st_d.cnt  = '0;
            st_d.mode = irq_mode_e'(mode_i);
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
        low_req_o = en_i && (st_q.cnt < low_len);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R1 / R2: the count never leaves the range of the active mode
    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= ((st_q.mode == MODE_DIGITAL) ? DIG_LAST : ANA_LAST));

    // R8: the active mode holds for the whole running period
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (en_i && st_q.cnt != '0) |-> $stable(st_q.mode));
endmodule

// File: rtl/sample_irq_shaper.sv
module sample_irq_shaper (
    input  logic clk,
    input  logic rst,
    input  logic low_req_i,
    output logic irq_n_o
);
    logic rise_n_d, rise_n_q;
    logic fall_n_d, fall_n_q;

    always_comb begin
        rise_n_d = rst ? 1'b1 : !low_req_i;
        fall_n_d = rst ? 1'b1 : rise_n_q;
        irq_n_o  = rise_n_q & fall_n_q;
    end

    always_ff @(posedge clk) begin
        rise_n_q <= rise_n_d;
    end

    always_ff @(negedge clk) begin
        fall_n_q <= fall_n_d;
    end

    // R5: when the rising-edge stage releases, the output stays low for another half cycle
    assert_half_tail_R5: assert property (@(negedge clk) disable iff (rst)
        $rose(rise_n_q) |-> !irq_n_o);
endmodule

// File: rtl/sample_irq_gen.sv
module sample_irq_gen #(
    parameter int DIG_PERIOD = 800,
    parameter int ANA_PERIOD = 972,
    parameter int DIG_LOW    = 6,
    parameter int ANA_LOW    = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_sel,
    input  logic irq_disable,
    output logic irq_n
);
    localparam int MAX_PERIOD = (DIG_PERIOD > ANA_PERIOD) ? DIG_PERIOD : ANA_PERIOD;
    localparam int CNT_W      = $clog2(MAX_PERIOD);

    logic low_req;

    sample_irq_counter #(
        .DIG_PERIOD(DIG_PERIOD),
        .ANA_PERIOD(ANA_PERIOD),
        .DIG_LOW   (DIG_LOW),
        .ANA_LOW   (ANA_LOW),
        .CNT_W     (CNT_W)
    ) counter_i (
        .clk      (clk),
        .rst      (rst),
        .en_i     (!irq_disable),
        .mode_i   (mode_sel),
        .low_req_o(low_req)
    );

    sample_irq_shaper shaper_i (
        .clk      (clk),
        .rst      (rst),
        .low_req_i(low_req),
        .irq_n_o  (irq_n)
    );

    // R6: one full cycle after the disable is seen, the output is high
    assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_disable) && irq_disable) |-> irq_n);

    // R7: after re-enable the first pulse starts at once
    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_disable) |=> !irq_n);
endmodule

// File: tb/sample_irq_gen_tb_top.sv
`timescale 1ns/1ps
module sample_irq_gen_tb_top;
    localparam real TCK = 5.0;

    typedef struct {
        real   width;
        real   period;
        real   start;
        string tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_sel = 1'b1;
    logic irq_disable = 1'b0;
    logic irq_n;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int done_cnt = 0;
    bit finished = 1'b0;
    exp_item_t exp_q[$];

    always #(TCK/2.0) clk = ~clk;

    sample_irq_gen dut_i (
        .clk        (clk),
        .rst        (rst),
        .mode_sel   (mode_sel),
        .irq_disable(irq_disable),
        .irq_n      (irq_n)
    );

    function automatic real absr(real v);
        return (v < 0.0) ? -v : v;
    endfunction

    task automatic chk(bit ok, string req, string what, real act, real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
        end
    endtask

    task automatic push(real w, real p, real s, string tag);
        exp_item_t it;
        it.width = w; it.period = p; it.start = s; it.tag = tag;
        exp_q.push_back(it);
        pushed++;
    endtask

    task automatic wait_done();
        wait (done_cnt == pushed);
    endtask

    // monitor: pops one expected item per pulse and compares edge times
    initial begin
        real tf, tr, prev;
        exp_item_t it;
        prev = 0.0;
        forever begin
            @(negedge irq_n);
            tf = $realtime;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected pulse at", tf, 0.0);
                @(posedge irq_n);
            end else begin
                it = exp_q.pop_front();
                if (it.start > 0.0)
                    chk(absr(tf - it.start) < 0.01, it.tag, "pulse start ns", tf, it.start);
                if (it.period > 0.0)
                    chk(absr(tf - prev - it.period) < 0.01, it.tag, "period ns", tf - prev, it.period);
                @(posedge irq_n);
                tr = $realtime;
                chk(absr(tr - tf - it.width) < 0.01, it.tag, "low width ns", tr - tf, it.width);
                done_cnt++;
            end
            prev = tf;
        end
    end

    // driver
    initial begin
        real t0;
        repeat (3) @(negedge clk);
        chk(irq_n == 1'b1, "R9", "irq_n in reset", real'(irq_n), 1.0);
        @(negedge clk);
        chk(irq_n == 1'b1, "R9", "irq_n in reset", real'(irq_n), 1.0);
        rst = 1'b0;
        t0 = $realtime;
        // R9 first pulse, R1 digital period, R3 digital width, R5 half cycle
        push(6.5*TCK, 0.0, t0 + TCK/2.0, "R9");
        push(6.5*TCK, 800.0*TCK, 0.0, "R1");
        push(6.5*TCK, 800.0*TCK, 0.0, "R3");
        wait_done();

        // R8: switch to analog during a digital pulse
        push(6.5*TCK, 800.0*TCK, 0.0, "R8");
        @(negedge irq_n);
        #1;
        mode_sel = 1'b0;
        push(5.5*TCK, 800.0*TCK, 0.0, "R8");
        push(5.5*TCK, 972.0*TCK, 0.0, "R2");
        push(5.5*TCK, 972.0*TCK, 0.0, "R4");
        wait_done();

        // R6: disable mid period, also pick digital while disabled
        @(negedge clk);
        irq_disable = 1'b1;
        mode_sel = 1'b1;
        for (int i = 0; i < 12; i++) begin
            repeat (100) @(negedge clk);
            chk(irq_n == 1'b1, "R6", "irq_n while disabled", real'(irq_n), 1.0);
        end

        // R7: re-enable restarts the count; R8 mode taken at once while disabled
        @(negedge clk);
        irq_disable = 1'b0;
        t0 = $realtime;
        push(6.5*TCK, 0.0, t0 + TCK/2.0, "R7");
        push(6.5*TCK, 800.0*TCK, 0.0, "R7");
        wait_done();

        // R7 again in analog mode, re-enable after a short disable
        @(negedge clk);
        irq_disable = 1'b1;
        mode_sel = 1'b0;
        repeat (37) @(negedge clk);
        chk(irq_n == 1'b1, "R6", "irq_n while disabled", real'(irq_n), 1.0);
        irq_disable = 1'b0;
        t0 = $realtime;
        push(5.5*TCK, 0.0, t0 + TCK/2.0, "R7");
        push(5.5*TCK, 972.0*TCK, 0.0, "R2");
        wait_done();

        @(negedge clk);
        irq_disable = 1'b1;
        repeat (20) @(negedge clk);
        chk(irq_n == 1'b1, "R6", "irq_n after final disable", real'(irq_n), 1.0);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // watchdog
    initial begin
        #(100000.0 * TCK);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=%0d expected=%0d pulses", done_cnt, pushed);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule